// File: doc/BRIEF.md
# Differential SAR Conversion Sequencer

This block is the digital control for a successive-approximation converter built around two matched binary-weighted capacitor arrays feeding opposite inputs of one comparator. While idle it holds the converter in acquisition: both sampling switches are closed, so the common terminals of the arrays sit at ground, and every element of both arrays is connected to its analog input. A rising edge on the conversion request input ends acquisition.

A conversion then runs from the block's own clock. First the two sampling switches open. One cycle later both arrays leave their inputs and go to ground. Then sixteen bit trials run, most significant bit first. Each trial sets the bit under test on the positive array, sets the opposite setting on the negative array, and keeps or drops that bit based on the comparator. After the last trial the block returns to acquisition. It presents the code of the sample it has just taken, with no pipeline delay, and marks the end of the conversion with a one-cycle valid strobe in the same cycle that busy drops.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After a synchronous reset, and whenever busy is low, the block is in acquisition. Both sampling switch enables are 1 (closed), every bit of both to-input vectors is 1, and every bit of both to-reference vectors is 0. After reset, valid is 0 and the code is 0.
- R2: A rising edge on conv_req sampled while busy is low makes busy 1 on the next cycle. In that first busy cycle both sampling switch enables are 0 and both to-input vectors are still all ones.
- R3: In the second busy cycle both to-input vectors are all zeros and both to-reference vectors are all zeros, so every element is on ground. A to-input bit is never 0 while a sampling switch is closed.
- R4: Sixteen trial cycles follow, from bit 15 down to bit 0. In the trial for bit k, arr_to_ref_pos holds the bits already kept above k, plus bit k set tentatively, and zeros below k. Each trial adds exactly one bit position to the set of decided positions.
- R5: A comparator input of 1 (positive node at or above negative node), sampled at the end of the trial for bit k, keeps bit k. A value of 0 clears it.
- R6: During trials the negative array mirrors the positive one. arr_to_ref_neg is the complement of arr_to_ref_pos over bit k and the bits above it, and 0 below bit k. No bit is 1 in both vectors.
- R7: Busy stays high for exactly 18 cycles (2 preamble and 16 trials). conv_valid is a single-cycle pulse in the first cycle that busy is low again.
- R8: In the valid cycle the code equals the result of this conversion's own trials, which is the sample just taken. The code changes only in a valid cycle or on reset, and otherwise holds until the next conversion ends.
- R9: A rising edge on conv_req while busy is high is ignored. The running conversion keeps its length and result, and no conversion starts afterwards.
- R10: Holding conv_req high starts only one conversion. A new one needs a fresh low-to-high transition.
- R11: A synchronous reset during a conversion returns the block to acquisition at once, with busy and valid low and the code cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_req | input | 1 | Conversion request; its rising edge ends acquisition |
| cmp_ge | input | 1 | Comparator result, 1 when positive node is at or above negative node |
| samp_sw_pos | output | 1 | Positive-side sampling switch, 1 = closed (common terminal to ground) |
| samp_sw_neg | output | 1 | Negative-side sampling switch, 1 = closed |
| arr_to_in_pos | output | 16 | Per-element positive array: 1 = on analog input |
| arr_to_in_neg | output | 16 | Per-element negative array: 1 = on analog input |
| arr_to_ref_pos | output | 16 | Per-element positive array when off input: 1 = reference, 0 = ground |
| arr_to_ref_neg | output | 16 | Per-element negative array when off input: 1 = reference, 0 = ground |
| busy | output | 1 | High from the cycle after the accepted request through the last trial |
| conv_valid | output | 1 | One-cycle strobe marking a new code |
| code | output | 16 | Result code of the most recent conversion |

## Verification
The hardest situation to reach from the ports is a trial sequence that follows a real analog sample. The keep or clear decision only means something if the comparator answers each tentative code as an input voltage would. The bench therefore models the comparator. At every trial cycle it compares a chosen sample value against the expected tentative code and drives cmp_ge from that. Samples with all bits set, no bits set, one bit set and mixed bits exercise every keep and clear path. Two further cases need careful timing: a request edge placed mid-trial, and a reset that lands in the middle of the trials after an earlier conversion has left a non-zero code. The bench reaches both by counting cycles from its own request edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [2:0] {
      ST_ACQ   = 3'd0,
      ST_OPEN  = 3'd1,
      ST_GND   = 3'd2,
      ST_TRIAL = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic pulse
);
   logic din_q;

   always_ff @(posedge clk) begin
      if (rst) din_q <= 1'b0;
      else     din_q <= din;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = din & ~din_q;
      end else begin : g_fall
         assign pulse = ~din & din_q;
      end
   endgenerate
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
   import sar_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start_pulse,
   input  logic       last_trial,
   output seq_state_t state,
   output logic       load_msb,
   output logic       step,
   output logic       busy,
   output logic       valid
);
   seq_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_ACQ, ST_DONE: nxt = start_pulse ? ST_OPEN : ST_ACQ;
         ST_OPEN:         nxt = ST_GND;
         ST_GND:          nxt = ST_TRIAL;
         ST_TRIAL:        nxt = last_trial ? ST_DONE : ST_TRIAL;
         default:         nxt = ST_ACQ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_ACQ;
      else     state <= nxt;
   end

   assign load_msb = (state == ST_GND);
   assign step     = (state == ST_TRIAL);
   assign busy     = (state == ST_OPEN) || (state == ST_GND) || (state == ST_TRIAL);
   assign valid    = (state == ST_DONE);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic             cmp_ge,
   output logic [NBITS-1:0] trial,
   output logic [NBITS-1:0] mask,
   output logic             last,
   output logic [NBITS-1:0] result
);
   localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] decided;

   // keep the tentative bit when the positive node wins, drop it otherwise
   always_comb begin
      decided = cmp_ge ? trial : (trial & ~mask);
   end

   assign last = mask[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         trial  <= '0;
         mask   <= '0;
         result <= '0;
      end else if (load) begin
         trial <= TOP_BIT;
         mask  <= TOP_BIT;
      end else if (step) begin
         trial <= decided | (mask >> 1);
         mask  <= mask >> 1;
         if (mask[0]) result <= decided;
      end
   end
endmodule

// File: rtl/sar_switch_drv.sv
module sar_switch_drv
   import sar_seq_pkg::*;
#(
   parameter int NBITS = 16
) (
   input  seq_state_t       state,
   input  logic [NBITS-1:0] trial,
   input  logic [NBITS-1:0] mask,
   output logic             samp_pos,
   output logic             samp_neg,
   output logic [NBITS-1:0] in_pos,
   output logic [NBITS-1:0] in_neg,
   output logic [NBITS-1:0] ref_pos,
   output logic [NBITS-1:0] ref_neg
);
   logic [NBITS-1:0] active;

   // a position is active once the bit under test is at or below it
   generate
      for (genvar k = 0; k < NBITS; k++) begin : g_act
         assign active[k] = |mask[k:0];
      end
   endgenerate

   always_comb begin
      samp_pos = 1'b0;
      samp_neg = 1'b0;
      in_pos   = '0;
      in_neg   = '0;
      ref_pos  = '0;
      ref_neg  = '0;
      unique case (state)
         ST_ACQ, ST_DONE: begin
            samp_pos = 1'b1;
            samp_neg = 1'b1;
            in_pos   = '1;
            in_neg   = '1;
         end
         ST_OPEN: begin
            in_pos = '1;
            in_neg = '1;
         end
         ST_GND: begin
         end
         ST_TRIAL: begin
            ref_pos = trial & active;
            ref_neg = ~trial & active;
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             conv_req,
   input  logic             cmp_ge,
   output logic             samp_sw_pos,
   output logic             samp_sw_neg,
   output logic [NBITS-1:0] arr_to_in_pos,
   output logic [NBITS-1:0] arr_to_in_neg,
   output logic [NBITS-1:0] arr_to_ref_pos,
   output logic [NBITS-1:0] arr_to_ref_neg,
   output logic             busy,
   output logic             conv_valid,
   output logic [NBITS-1:0] code
);
   generate
      if (NBITS < 2 || NBITS > 32) begin : g_bad_width
         $error("sar_seq_ctrl: NBITS must lie in 2..32");
      end
   endgenerate

   seq_state_t       state;
   logic             start_pulse;
   logic             load_msb;
   logic             step;
   logic             last_trial;
   logic [NBITS-1:0] trial;
   logic [NBITS-1:0] mask;

   sar_edge_det #(.RISING(1'b1)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .din   (conv_req),
      .pulse (start_pulse)
   );

   sar_seq_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .start_pulse (start_pulse),
      .last_trial  (last_trial),
      .state       (state),
      .load_msb    (load_msb),
      .step        (step),
      .busy        (busy),
      .valid       (conv_valid)
   );

   sar_trial_reg #(.NBITS(NBITS)) u_trial (
      .clk    (clk),
      .rst    (rst),
      .load   (load_msb),
      .step   (step),
      .cmp_ge (cmp_ge),
      .trial  (trial),
      .mask   (mask),
      .last   (last_trial),
      .result (code)
   );

   sar_switch_drv #(.NBITS(NBITS)) u_sw (
      .state    (state),
      .trial    (trial),
      .mask     (mask),
      .samp_pos (samp_sw_pos),
      .samp_neg (samp_sw_neg),
      .in_pos   (arr_to_in_pos),
      .in_neg   (arr_to_in_neg),
      .ref_pos  (arr_to_ref_pos),
      .ref_neg  (arr_to_ref_neg)
   );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int NBITS = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             samp_sw_pos,
   input logic             samp_sw_neg,
   input logic [NBITS-1:0] arr_to_in_pos,
   input logic [NBITS-1:0] arr_to_in_neg,
   input logic [NBITS-1:0] arr_to_ref_pos,
   input logic [NBITS-1:0] arr_to_ref_neg,
   input logic             busy,
   input logic             conv_valid,
   input logic [NBITS-1:0] code
);
   localparam int CW       = $clog2(NBITS + 4) + 1;
   localparam int BUSY_LEN = NBITS + 2;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (rst || !busy) busy_cnt <= '0;
      else              busy_cnt <= busy_cnt + 1'b1;
   end

   // R1
   acq_cfg_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (samp_sw_pos && samp_sw_neg && (&arr_to_in_pos) && (&arr_to_in_neg)
                 && (arr_to_ref_pos == '0) && (arr_to_ref_neg == '0)));

   // R2
   open_first_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (!samp_sw_pos && !samp_sw_neg && (&arr_to_in_pos) && (&arr_to_in_neg)));

   // R3
   in_drop_chk: assert property (@(posedge clk) disable iff (rst)
      ((arr_to_in_pos != '1) || (arr_to_in_neg != '1)) |-> (!samp_sw_pos && !samp_sw_neg));

   // R4
   trial_grow_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && ((arr_to_ref_pos | arr_to_ref_neg) != '0)
            && ($past(arr_to_ref_pos | arr_to_ref_neg) != '0))
      |-> ($countones(arr_to_ref_pos | arr_to_ref_neg)
           == $countones($past(arr_to_ref_pos | arr_to_ref_neg)) + 1));

   // R6
   mirror_chk: assert property (@(posedge clk) disable iff (rst)
      ((arr_to_ref_pos & arr_to_ref_neg) == '0));

   // R7
   valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
      conv_valid |-> (!busy && $past(busy)));

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(busy)) |-> (busy_cnt == CW'(BUSY_LEN)));

   // R8
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(code)) |-> conv_valid);
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .samp_sw_pos    (samp_sw_pos),
   .samp_sw_neg    (samp_sw_neg),
   .arr_to_in_pos  (arr_to_in_pos),
   .arr_to_in_neg  (arr_to_in_neg),
   .arr_to_ref_pos (arr_to_ref_pos),
   .arr_to_ref_neg (arr_to_ref_neg),
   .busy           (busy),
   .conv_valid     (conv_valid),
   .code           (code)
);

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
   localparam int CLK_P   = 10;
   localparam int NB      = 16;
   localparam int WD_MAX  = 20000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          conv_req = 1'b0;
   logic          cmp_ge = 1'b0;
   logic          samp_sw_pos, samp_sw_neg;
   logic [NB-1:0] arr_to_in_pos, arr_to_in_neg, arr_to_ref_pos, arr_to_ref_neg;
   logic          busy, conv_valid;
   logic [NB-1:0] code;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   sar_seq_ctrl #(.NBITS(NB)) dut (
      .clk            (clk),
      .rst            (rst),
      .conv_req       (conv_req),
      .cmp_ge         (cmp_ge),
      .samp_sw_pos    (samp_sw_pos),
      .samp_sw_neg    (samp_sw_neg),
      .arr_to_in_pos  (arr_to_in_pos),
      .arr_to_in_neg  (arr_to_in_neg),
      .arr_to_ref_pos (arr_to_ref_pos),
      .arr_to_ref_neg (arr_to_ref_neg),
      .busy           (busy),
      .conv_valid     (conv_valid),
      .code           (code)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_MAX && !ended) begin
         ended = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected < %0d)", WD_MAX, cyc, WD_MAX);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic chk_acq(input string req);
      chk({req, " busy"}, busy, 0);
      chk({req, " samp"}, {samp_sw_pos, samp_sw_neg}, 2'b11);
      chk({req, " in_pos"}, arr_to_in_pos, 16'hFFFF);
      chk({req, " in_neg"}, arr_to_in_neg, 16'hFFFF);
      chk({req, " ref"}, {arr_to_ref_pos, arr_to_ref_neg}, 0);
   endtask

   // mode 0 normal, 1 request edge inside trials, 2 request held high
   task automatic t_convert(input logic [NB-1:0] s, input int mode);
      logic [NB-1:0] exp_p, exp_n;
      @(negedge clk);
      conv_req = 1'b1;
      @(negedge clk);
      chk("R2 busy", busy, 1);
      chk("R2 samp open", {samp_sw_pos, samp_sw_neg}, 2'b00);
      chk("R2 in kept", {arr_to_in_pos, arr_to_in_neg}, 32'hFFFFFFFF);
      if (mode != 2) conv_req = 1'b0;
      @(negedge clk);
      chk("R3 busy", busy, 1);
      chk("R3 in off", {arr_to_in_pos, arr_to_in_neg}, 0);
      chk("R3 ground", {arr_to_ref_pos, arr_to_ref_neg}, 0);
      chk("R3 samp open", {samp_sw_pos, samp_sw_neg}, 2'b00);
      for (int k = NB-1; k >= 0; k--) begin
         @(negedge clk);
         exp_p = NB'((32'(s) & ~((32'd1 << (k+1)) - 1)) | (32'd1 << k));
         exp_n = NB'(~32'(exp_p) & ~((32'd1 << k) - 1));
         chk("R7 busy in trial", busy, 1);
         chk("R4 R5 ref_pos", arr_to_ref_pos, exp_p);
         chk("R6 ref_neg", arr_to_ref_neg, exp_n);
         cmp_ge = (s >= exp_p);
         if (mode == 1 && k == 10) conv_req = 1'b1;
         if (mode == 1 && k == 9)  conv_req = 1'b0;
      end
      @(negedge clk);
      cmp_ge = 1'b0;
      chk("R7 valid pulse", conv_valid, 1);
      chk("R8 code", code, s);
      chk_acq("R7 back to acq");
      @(negedge clk);
      chk("R7 valid one cycle", conv_valid, 0);
      chk("R8 code held", code, s);
      chk_acq("R1 idle");
      if (mode != 0) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(mode == 1 ? "R9 no restart" : "R10 no retrigger", busy, 0);
         end
         chk("R8 code still held", code, s);
         conv_req = 1'b0;
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk_acq("R1 reset");
      chk("R1 valid", conv_valid, 0);
      chk("R1 code", code, 0);
   endtask

   task automatic t_mid_reset(input logic [NB-1:0] s);
      @(negedge clk);
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      repeat (7) begin
         @(negedge clk);
         cmp_ge = 1'b1;
      end
      chk("R11 busy before reset", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      cmp_ge = 1'b0;
      chk_acq("R11 reset acq");
      chk("R11 valid", conv_valid, 0);
      chk("R11 code cleared", code, 0);
      @(negedge clk);
      chk("R11 stays idle", busy, 0);
      t_convert(s, 0);
   endtask

   initial begin
      t_reset();
      t_convert(16'hA5C3, 0);
      t_convert(16'h0000, 0);
      t_convert(16'hFFFF, 0);
      t_convert(16'h8000, 0);
      t_convert(16'h7FFF, 0);
      t_convert(16'h1234, 1);
      t_convert(16'h0F0F, 2);
      t_mid_reset(16'h5A01);
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule